// File: doc/BRIEF.md
# External Memory Bus Cycle Engine

This block runs byte-wide read and write cycles on an asynchronous parallel memory bus with a 19-bit address, 8-bit data and active-low memory-request, read and write strobes. A host issues one request at a time, made of an operation code, an address, a write byte and a fill length. The engine sequences the strobes in fixed numbers of clocks and raises a one-clock done pulse when the cycle ends. For reads, the captured byte is also returned.

A fill operation writes one byte value to a run of consecutive addresses. The memory request stays low for the whole run, and only the write strobe pulses once per byte. Bus ownership comes in as a level, and the engine turns it into a registered pad enable. While the enable is low, the address, strobe and data pads must be at high impedance. The memory is assumed to answer within the fixed strobe widths, so the block has no wait input.

Operation codes on `req_op_i` are 2'b00 read, 2'b01 single write and 2'b10 fill. Code 2'b11 behaves as a single write.

Top module: `membus_cycle_engine`

## Requirements
- R1: While reset is held, `mreq_n_o`, `rd_n_o` and `wr_n_o` are high, and `bus_oe_o`, `data_oe_o`, `done_o` and `busy_o` are low.
- R2: `bus_oe_o` follows `bus_own_i` one clock later. In every cycle where `bus_oe_o` rises, all three strobes are high.
- R3: A read pulls `mreq_n_o` low the clock after acceptance. After SETUP_CLKS (1) clocks, `rd_n_o` goes low for RD_CLKS (3) clocks, then stays high for one more clock with `mreq_n_o` still low. `data_oe_o` stays low the whole time.
- R4: Read data is sampled in the last clock that `rd_n_o` is low. It appears on `rdata_o` no later than `done_o` and holds until the next read capture.
- R5: A single write drives `data_oe_o` and `data_o` while `mreq_n_o` is low, for SETUP_CLKS (1) clocks, then `wr_n_o` low for WR_CLKS (2) clocks, then one clock with `wr_n_o` high and `mreq_n_o` low. The cycle is 4 clocks of `mreq_n_o` low in all.
- R6: A fill of N bytes keeps `mreq_n_o` low for 4·N consecutive clocks with a single falling edge. It gives N write pulses at addresses start, start+1, … (wrapping modulo 2^19), each carrying the fill byte.
- R7: A fill with length zero raises `done_o` one clock after acceptance and never lowers `mreq_n_o`.
- R8: A request accepted while `bus_oe_o` is low raises `done_o` and `err_o` together one clock later and starts no strobe.
- R9: `done_o` is high for exactly one clock, in the first clock after the last strobe where `mreq_n_o` is high again. `busy_o` is high from acceptance through that clock.
- R10: `rd_n_o` and `wr_n_o` are never low together, and neither is low while `mreq_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_own_i | input | 1 | Bus ownership granted (level) |
| req_valid_i | input | 1 | Request strobe, taken when `busy_o` is low |
| req_op_i | input | 2 | 00 read, 01 write, 10 fill, 11 write |
| req_addr_i | input | 19 | Address, or start address of a fill |
| req_wdata_i | input | 8 | Write or fill byte |
| req_len_i | input | 16 | Fill length in bytes |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | With `done_o`: request rejected because the bus is not owned |
| rdata_o | output | 8 | Last byte read |
| bus_oe_o | output | 1 | Pad enable for address and strobes |
| addr_o | output | 19 | Address pads |
| mreq_n_o | output | 1 | Memory request strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| data_o | output | 8 | Data pads, out |
| data_oe_o | output | 1 | Data pad enable |
| data_i | input | 8 | Data pads, in |

## Verification
Single writes and reads are run at two addresses whose upper bits differ. A read-after-write tells a correct data path apart from stale or shifted capture, and a read of an untouched address shows the value comes from the bus and not from a held register. A four-byte fill that starts two bytes below the top of the address space checks the per-byte addresses across the wrap, and the single low-going request edge separates a held burst from repeated cycles. A zero-length fill and requests made without ownership are followed by reads of the addresses they could have written, which shows that nothing reached the memory.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_FILL  = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } state_e;
endpackage

// File: rtl/membus_pad_enable.sv
module membus_pad_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic own_i,
  output logic oe_o
);
  logic oe_q;

  // one register stage: strobes are settled high before the pads turn on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= own_i;
  end

  assign oe_o = oe_q;

  a_r2_oe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_i |=> oe_o);
endmodule

// File: rtl/membus_strobe_timer.sv
module membus_strobe_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/membus_burst_track.sv
module membus_burst_track #(
  parameter int ADDR_W = 19,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      rem_q  <= len_i;
    end else if (step_i) begin
      addr_q <= addr_q + 1'b1;   // wraps modulo 2^ADDR_W
      rem_q  <= rem_q - 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (rem_q == LEN_W'(1));
endmodule

// File: rtl/membus_cycle_engine.sv
module membus_cycle_engine
  import membus_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int LEN_W      = 16,
  parameter int SETUP_CLKS = 1,
  parameter int RD_CLKS    = 3,
  parameter int WR_CLKS    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_own_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mreq_n_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] data_i
);
  localparam int MAX_RW = (RD_CLKS > WR_CLKS) ? RD_CLKS : WR_CLKS;
  localparam int MAX_C  = (MAX_RW > SETUP_CLKS) ? MAX_RW : SETUP_CLKS;
  localparam int CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CLKS - 1);
  localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CLKS - 1);
  localparam logic [CNT_W-1:0] WR_LD    = CNT_W'(WR_CLKS - 1);

  state_e            state_q, state_d;
  logic              is_read_q, err_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              tmr_load, tmr_last;
  logic [CNT_W-1:0]  tmr_val;
  logic              bst_load, bst_step, bst_last;
  logic [LEN_W-1:0]  bst_len;
  logic              accept, cyc_act, capture;

  membus_pad_enable u_pad_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .own_i (bus_own_i),
    .oe_o  (bus_oe_o)
  );

  membus_strobe_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .last_o(tmr_last)
  );

  membus_burst_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_burst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(bst_load),
    .step_i(bst_step),
    .addr_i(req_addr_i),
    .len_i (bst_len),
    .addr_o(addr_o),
    .last_o(bst_last)
  );

  assign accept  = (state_q == ST_IDLE) && req_valid_i;
  assign bst_len = (op_e'(req_op_i) == OP_FILL) ? req_len_i : LEN_W'(1);
  assign capture = (state_q == ST_STROBE) && tmr_last && is_read_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = SETUP_LD;
    bst_load = 1'b0;
    bst_step = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid_i) begin
        if (!bus_oe_o || (op_e'(req_op_i) == OP_FILL && req_len_i == '0)) begin
          state_d = ST_DONE;
        end else begin
          state_d  = ST_ADDR;
          tmr_load = 1'b1;
          bst_load = 1'b1;
        end
      end
      ST_ADDR: if (tmr_last) begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = is_read_q ? RD_LD : WR_LD;
      end
      ST_STROBE: if (tmr_last) state_d = ST_HOLD;
      ST_HOLD: begin
        if (bst_last) begin
          state_d = ST_DONE;
        end else begin
          state_d  = ST_ADDR;   // next fill byte, request stays low
          tmr_load = 1'b1;
          bst_step = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      is_read_q <= 1'b0;
      err_q     <= 1'b0;
      wdata_q   <= '0;
      rdata_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        is_read_q <= (op_e'(req_op_i) == OP_READ);
        err_q     <= !bus_oe_o;
        wdata_q   <= req_wdata_i;
      end
      if (capture) rdata_q <= data_i;
    end
  end

  assign cyc_act   = (state_q == ST_ADDR) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
  assign mreq_n_o  = !cyc_act;
  assign rd_n_o    = !((state_q == ST_STROBE) && is_read_q);
  assign wr_n_o    = !((state_q == ST_STROBE) && !is_read_q);
  assign data_oe_o = cyc_act && !is_read_q;
  assign data_o    = wdata_q;
  assign rdata_o   = rdata_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign err_o     = done_o && err_q;

  a_r10_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  a_r10_strobe_in_mreq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> !mreq_n_o);
  a_r3_read_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !data_oe_o);
  a_r2_enable_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> (mreq_n_o && rd_n_o && wr_n_o));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_reject_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && mreq_n_o && $past(mreq_n_o)));
  a_r6_mreq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !bst_last) |=> !mreq_n_o);
  a_r4_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture |=> $stable(rdata_o));
endmodule

// File: tb/membus_cycle_engine_tb.sv
module membus_cycle_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT_CLKS = 50000;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        bus_own_i, req_valid_i;
  logic [1:0]  req_op_i;
  logic [18:0] req_addr_i;
  logic [7:0]  req_wdata_i;
  logic [15:0] req_len_i;
  logic        busy_o, done_o, err_o, bus_oe_o, mreq_n_o, rd_n_o, wr_n_o, data_oe_o;
  logic [7:0]  rdata_o, data_o, data_i;
  logic [18:0] addr_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  membus_cycle_engine u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_own_i(bus_own_i),
    .req_valid_i(req_valid_i), .req_op_i(req_op_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .req_len_i(req_len_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
    .bus_oe_o(bus_oe_o), .addr_o(addr_o), .mreq_n_o(mreq_n_o),
    .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .data_o(data_o),
    .data_oe_o(data_oe_o), .data_i(data_i)
  );

  // memory model, indexed by the low 10 address bits; written only by the monitor
  logic [7:0] mem [0:1023];
  bit mem_ready = 1'b0;
  assign data_i = (!rd_n_o) ? mem[addr_o[9:0]] : 8'h00;

  typedef struct packed {
    logic        is_read;
    logic [18:0] addr;
    logic [7:0]  data;
  } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0, n_bad = 0;
  int mon_cmp = 0, mon_bad = 0;
  int overlap_seen = 0, outside_seen = 0, rdrive_seen = 0;
  int rd_run = 0, wr_run = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic mcheck(input bit ok, input string req, input string what,
                        input int act, input int exp);
    mon_cmp++;
    if (!ok) begin
      mon_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected writes at each write-strobe release, expected reads at done
  always @(negedge clk_i) begin
    if (!mem_ready) begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
      mem_ready = 1'b1;
    end
    if (rst_ni) begin
      if (!rd_n_o && !wr_n_o) overlap_seen++;
      if ((!rd_n_o || !wr_n_o) && mreq_n_o) outside_seen++;
      if (!rd_n_o && data_oe_o) rdrive_seen++;
      if (!rd_n_o) rd_run++;
      else if (rd_run != 0) begin
        mcheck(rd_run == 3, "R3", "read strobe width", rd_run, 3);
        rd_run = 0;
      end
      if (!wr_n_o) wr_run++;
      else if (wr_run != 0) begin
        exp_t e;
        mcheck(wr_run == 2, "R5", "write strobe width", wr_run, 2);
        wr_run = 0;
        if (exp_q.size() == 0 || exp_q[0].is_read) begin
          mcheck(1'b0, "R8", "unexpected write at addr", int'(addr_o), 0);
        end else begin
          e = exp_q.pop_front();
          mcheck(addr_o == e.addr, "R6", "write address", int'(addr_o), int'(e.addr));
          mcheck(data_o == e.data, "R5", "write data", int'(data_o), int'(e.data));
          mcheck(data_oe_o, "R5", "data enable during write", int'(data_oe_o), 1);
        end
        mem[addr_o[9:0]] = data_o;
      end
      if (done_o && !err_o && exp_q.size() != 0 && exp_q[0].is_read) begin
        exp_t e;
        e = exp_q.pop_front();
        mcheck(rdata_o == e.data, "R4", "read data", int'(rdata_o), int'(e.data));
      end
    end
  end

  int  lat, mq_cyc, mq_falls, done_after;
  bit  saw_err, saw_busy;

  task automatic do_req(input logic [1:0] op, input logic [18:0] a,
                        input logic [7:0] d, input logic [15:0] n, input bit runs);
    bit prev_m;
    if (runs) begin
      if (op == 2'b00) exp_q.push_back({1'b1, a, d});
      else if (op == 2'b10) begin
        for (int i = 0; i < int'(n); i++) exp_q.push_back({1'b0, 19'(a + 19'(i)), d});
      end else exp_q.push_back({1'b0, a, d});
    end
    @(negedge clk_i);
    req_op_i = op; req_addr_i = a; req_wdata_i = d; req_len_i = n;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 0; mq_cyc = 0; mq_falls = 0; prev_m = 1'b1; saw_err = 1'b0; saw_busy = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      if (!mreq_n_o) begin
        mq_cyc++;
        if (prev_m) mq_falls++;
      end
      prev_m = mreq_n_o;
      if (!busy_o) saw_busy = 1'b0;
      if (done_o) begin
        saw_err = err_o;
        break;
      end
      lat++;
      @(negedge clk_i);
    end
    @(negedge clk_i);
    done_after = int'(done_o);
  endtask

  bit timed_out = 1'b0;

  initial begin
    rst_ni = 1'b0; bus_own_i = 1'b0; req_valid_i = 1'b0;
    req_op_i = 2'b00; req_addr_i = '0; req_wdata_i = '0; req_len_i = '0;
    fork
      begin
        logic [7:0] v200, v100, v300;
        repeat (3) @(negedge clk_i);
        // R1 reset state
        check(mreq_n_o && rd_n_o && wr_n_o, "R1", "strobes in reset",
              {mreq_n_o, rd_n_o, wr_n_o}, 7);
        check(!bus_oe_o && !data_oe_o, "R1", "enables in reset", {bus_oe_o, data_oe_o}, 0);
        check(!done_o && !busy_o, "R1", "done/busy in reset", {done_o, busy_o}, 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        v200 = mem[10'h200]; v100 = mem[10'h100]; v300 = mem[10'h300];

        // R8 request without ownership
        do_req(2'b01, 19'h00300, 8'hC3, 16'd1, 1'b0);
        check(lat == 0, "R8", "reject latency", lat, 0);
        check(saw_err, "R8", "err with done", int'(saw_err), 1);
        check(mq_cyc == 0, "R8", "mreq low clocks", mq_cyc, 0);

        // R2 ownership to pad enable, one clock lag
        @(negedge clk_i);
        bus_own_i = 1'b1;
        check(!bus_oe_o, "R2", "enable before edge", int'(bus_oe_o), 0);
        @(negedge clk_i);
        check(bus_oe_o, "R2", "enable after one clock", int'(bus_oe_o), 1);
        check(mreq_n_o && rd_n_o && wr_n_o, "R2", "strobes at enable",
              {mreq_n_o, rd_n_o, wr_n_o}, 7);

        // R5 single write, R9 done shape
        do_req(2'b01, 19'h5A3C1, 8'h3C, 16'd0, 1'b1);
        check(lat == 4 && mq_cyc == 4, "R5", "write mreq clocks", mq_cyc, 4);
        check(!saw_err, "R5", "write err", int'(saw_err), 0);
        check(done_after == 0, "R9", "done width", done_after, 0);
        check(saw_busy, "R9", "busy through cycle", int'(saw_busy), 1);

        // R3/R4 read back and read untouched location
        do_req(2'b00, 19'h5A3C1, 8'h3C, 16'd0, 1'b1);
        check(lat == 5 && mq_cyc == 5, "R3", "read mreq clocks", mq_cyc, 5);
        check(done_after == 0, "R9", "done width after read", done_after, 0);
        do_req(2'b00, 19'h00200, v200, 16'd0, 1'b1);
        repeat (5) @(negedge clk_i);
        check(rdata_o == v200, "R4", "read data held", int'(rdata_o), int'(v200));

        // R6 fill across address wrap
        do_req(2'b10, 19'h7FFFE, 8'hA5, 16'd4, 1'b1);
        check(mq_cyc == 16 && lat == 16, "R6", "fill mreq clocks", mq_cyc, 16);
        check(mq_falls == 1, "R6", "mreq falling edges", mq_falls, 1);
        do_req(2'b00, 19'h00001, 8'hA5, 16'd0, 1'b1);

        // R7 zero-length fill
        do_req(2'b10, 19'h00100, 8'h77, 16'd0, 1'b1);
        check(lat == 0 && mq_cyc == 0, "R7", "zero fill mreq clocks", mq_cyc, 0);
        check(!saw_err, "R7", "zero fill err", int'(saw_err), 0);
        do_req(2'b00, 19'h00100, v100, 16'd0, 1'b1);

        // R8 again after release, then confirm memory untouched
        @(negedge clk_i);
        bus_own_i = 1'b0;
        repeat (2) @(negedge clk_i);
        check(!bus_oe_o, "R2", "enable released", int'(bus_oe_o), 0);
        do_req(2'b10, 19'h00300, 8'h11, 16'd3, 1'b0);
        check(saw_err && mq_cyc == 0, "R8", "fill rejected", int'(saw_err), 1);
        bus_own_i = 1'b1;
        repeat (2) @(negedge clk_i);
        do_req(2'b00, 19'h00300, v300, 16'd0, 1'b1);

        repeat (3) @(negedge clk_i);
        check(overlap_seen == 0, "R10", "rd/wr overlap clocks", overlap_seen, 0);
        check(outside_seen == 0, "R10", "strobe outside mreq", outside_seen, 0);
        check(rdrive_seen == 0, "R3", "data driven during read", rdrive_seen, 0);
        check(exp_q.size() == 0, "R6", "pending expected items", exp_q.size(), 0);
      end
      begin
        repeat (TIMEOUT_CLKS) @(posedge clk_i);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) check(1'b0, "R9", "watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + mon_cmp, n_bad + mon_bad);
    $finish;
  end
endmodule